// File: doc/BRIEF.md
# Triangle-Carrier High-Side PWM with Bootstrap Refresh

This block produces the switching waveform for the high-side switches of a three-phase bridge. An up/down counter forms a symmetric triangle carrier. It is compared with a level derived from a digital speed command, which gives the high-side PWM gate. The same carrier places a short low-side refresh pulse around the carrier bottom. That pulse recharges the bootstrap supply of the phase whose high side is modulating. The commutation table downstream routes both gates to the proper phase.

The command is mapped linearly between a 0% code and a 100% code. A command below a lower all-off code forces both gates low and raises an all-off flag at once. The low-side refresh is only allowed while the command lies between the 0% code and a mid-duty cut code. Above the cut code the refresh stays off and the high side keeps modulating.

A current-limit comparator input cuts the high-side gate within the same carrier cycle. Comparator activity during a blanking window after each high-side turn-on is ignored. Once tripped, the cut holds until the next PWM-on edge, which the block also reports as a one-cycle strobe.

Top module: `tri_pwm_refresh`

## Requirements
- R1: While `rst` is high, and in the first output cycle after it falls, `hs_pwm`, `ls_refresh`, `all_off` and `pwm_on_stb` are all low.
- R2: The carrier period is 2*HALF_CYC clock cycles. With the command held and no current limit, `hs_pwm` is high for exactly 2*T cycles of every period. T = floor((cmd-ZERO_CODE)*HALF_CYC/(FULL_CODE-ZERO_CODE)), clamped to the range 0..HALF_CYC. The high-side pulse is centred on the carrier top.
- R3: The command is sampled for the duty level only at the carrier bottom. A command change in mid-period does not alter the on-time of the period already running.
- R4: When `speed_cmd` < ALLOFF_CODE, the next output cycle has `all_off` high and both `hs_pwm` and `ls_refresh` low, without waiting for the carrier bottom.
- R5: A command at or below ZERO_CODE gives 0% duty (`hs_pwm` never high). A command at or above FULL_CODE gives 100% duty (`hs_pwm` high for the whole period).
- R6: When the command sampled at the carrier top lies in [ZERO_CODE, CUT_CODE), `ls_refresh` is high while the carrier value is below HALF_CYC/REFRESH_DIV. That is 2*(HALF_CYC/REFRESH_DIV)-1 cycles per period, centred on the bottom.
- R7: When the command sampled at the carrier top is CUT_CODE or above, `ls_refresh` stays low for the whole following period.
- R8: `hs_pwm` and `ls_refresh` are never high together. `ls_refresh` rises only after `hs_pwm` has been low for at least DEAD_CYC+1 consecutive cycles.
- R9: `pwm_on_stb` is a one-cycle pulse in the output cycle where the carrier compare turns on. Unless the block is all-off, `hs_pwm` rises in that same cycle.
- R10: If `ilim` is high at a clock edge after `hs_pwm` has been high for more than MASK_CYC cycles, `hs_pwm` is low from the next cycle. It stays low until the next `pwm_on_stb`, even if `ilim` falls.
- R11: `ilim` is ignored during the first MASK_CYC cycles of each high-side pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_cmd | input | CMD_W | Speed command code |
| ilim | input | 1 | Current-limit comparator output, synchronous to clk |
| hs_pwm | output | 1 | High-side PWM gate |
| ls_refresh | output | 1 | Low-side bootstrap refresh gate |
| all_off | output | 1 | Command is in the all-off zone |
| pwm_on_stb | output | 1 | One-cycle strobe at each PWM-on edge |

## Verification
The assertions assume that `speed_cmd` and `ilim` are already synchronous to `clk`. They also assume the codes are ordered ALLOFF_CODE < ZERO_CODE < CUT_CODE < FULL_CODE, and that the refresh window lies below the lowest high-side compare level reachable under the cut code. The bench changes both inputs only at falling edges. It keeps the default code ordering and picks a refresh divisor and half-period that meet the window condition. Random commands span the full code range, including the all-off zone. Random current-limit pulses are therefore seen both inside and outside the blanking window.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

    // Command zones, lowest first
    typedef enum logic [1:0] {
        ZONE_OFF     = 2'd0,
        ZONE_IDLE    = 2'd1,
        ZONE_REFRESH = 2'd2,
        ZONE_DRIVE   = 2'd3
    } zone_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    // Classify a command code against the zone thresholds
    function automatic zone_e classify(input int cmd, input int off_code,
                                       input int zero_code, input int cut_code);
        if (cmd < off_code)
            return ZONE_OFF;
        else if (cmd < zero_code)
            return ZONE_IDLE;
        else if (cmd < cut_code)
            return ZONE_REFRESH;
        else
            return ZONE_DRIVE;
    endfunction

    // Half-period on-time in carrier units for a command code
    function automatic int duty_thr(input int cmd, input int zero_code,
                                    input int full_code, input int half);
        if (cmd <= zero_code)
            return 0;
        else if (cmd >= full_code)
            return half;
        else
            return ((cmd - zero_code) * half) / (full_code - zero_code);
    endfunction

endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
    parameter int HALF_CYC = 6250,
    parameter int CNT_W    = $clog2(HALF_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             rising,
    output logic             at_bottom,
    output logic             at_top
);

    localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(HALF_CYC);
    localparam logic [CNT_W-1:0] TURN_V = CNT_W'(HALF_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            if (cnt == TURN_V) begin
                cnt    <= TOP_V;
                rising <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end else begin
            if (cnt == CNT_W'(1)) begin
                cnt    <= '0;
                rising <= 1'b1;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    assign at_bottom = rising && (cnt == '0);
    assign at_top    = !rising && (cnt == TOP_V);

    // R2: carrier moves by exactly one unit per clock and never leaves its range
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == $past(cnt) - CNT_W'(1))));
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP_V);

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import tri_pwm_pkg::*;
#(
    parameter int CMD_W       = 8,
    parameter int HALF_CYC    = 6250,
    parameter int CNT_W       = $clog2(HALF_CYC + 1),
    parameter int ALLOFF_CODE = 51,
    parameter int ZERO_CODE   = 82,
    parameter int FULL_CODE   = 212,
    parameter int CUT_CODE    = 149
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd,
    input  logic [CNT_W-1:0] cnt,
    input  logic             rising,
    input  logic             at_bottom,
    input  logic             at_top,
    output logic             hit,
    output logic             pwm_lvl,
    output logic             on_edge,
    output logic             ref_en
);

    logic [CNT_W-1:0] lvl_q;
    zone_e            zone_c;
    int               thr_c;

    always_comb begin
        thr_c  = duty_thr(int'(cmd), ZERO_CODE, FULL_CODE, HALF_CYC);
        zone_c = classify(int'(cmd), ALLOFF_CODE, ZERO_CODE, CUT_CODE);
    end

    // Duty level reloads only at the bottom; refresh enable at the top,
    // so neither the high-side pulse nor the refresh window is split
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= CNT_W'(HALF_CYC);
            ref_en <= 1'b0;
        end else begin
            if (at_bottom)
                lvl_q <= CNT_W'(HALF_CYC - thr_c);
            if (at_top)
                ref_en <= (zone_c == ZONE_REFRESH);
        end
    end

    // Rising half uses >=, falling half uses > : exactly 2*thr hits per period
    assign hit = rising ? (cnt >= lvl_q) : (cnt > lvl_q);

    always_ff @(posedge clk) begin
        if (rst)
            pwm_lvl <= 1'b0;
        else
            pwm_lvl <= hit;
    end

    assign on_edge = hit && !pwm_lvl;

    // R3: compare level is frozen except across a bottom edge
    p_lvl_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !at_bottom |=> $stable(lvl_q));

endmodule

// File: rtl/oc_blanker.sv
module oc_blanker #(
    parameter int MASK_CYC = 250,
    parameter int BW       = $clog2(MASK_CYC + 2)
) (
    input  logic clk,
    input  logic rst,
    input  logic ilim,
    input  logic pwm_lvl,
    input  logic on_edge,
    output logic block_hs,
    output logic latched
);

    logic [BW-1:0] bl_cnt;
    logic          trip;

    // Blanking counter restarts at every PWM-on edge
    always_ff @(posedge clk) begin
        if (rst)
            bl_cnt <= '0;
        else if (on_edge)
            bl_cnt <= BW'(MASK_CYC);
        else if (bl_cnt != '0)
            bl_cnt <= bl_cnt - BW'(1);
    end

    assign trip = pwm_lvl && (bl_cnt == '0) && ilim && !on_edge;

    // Cut holds until the next on edge releases it
    always_ff @(posedge clk) begin
        if (rst)
            latched <= 1'b0;
        else if (on_edge)
            latched <= 1'b0;
        else if (trip)
            latched <= 1'b1;
    end

    assign block_hs = !on_edge && (latched || trip);

    // R11: a cut is never latched while the blanking window is still running
    p_blank_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(latched) |-> ($past(bl_cnt) == '0));

endmodule

// File: rtl/refresh_ctl.sv
module refresh_ctl #(
    parameter int CNT_W    = 13,
    parameter int REF_W    = 1250,
    parameter int DEAD_CYC = 125,
    parameter int DW       = $clog2(DEAD_CYC + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ref_en,
    input  logic             off_c,
    input  logic             hs_now,
    input  logic             hs_next,
    output logic             ls_next
);

    localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

    logic [DW-1:0] dt_cnt;

    // Cycles since the high-side gate went low, saturating at DEAD_CYC
    always_ff @(posedge clk) begin
        if (rst)
            dt_cnt <= DEAD_V;
        else if (hs_now)
            dt_cnt <= '0;
        else if (dt_cnt != DEAD_V)
            dt_cnt <= dt_cnt + DW'(1);
    end

    assign ls_next = ref_en && (cnt < CNT_W'(REF_W)) && !off_c &&
                     !hs_now && !hs_next && (dt_cnt == DEAD_V);

endmodule

// File: rtl/tri_pwm_refresh.sv
module tri_pwm_refresh
    import tri_pwm_pkg::*;
#(
    parameter int CMD_W       = 8,
    parameter int HALF_CYC    = 6250,
    parameter int ALLOFF_CODE = 51,
    parameter int ZERO_CODE   = 82,
    parameter int FULL_CODE   = 212,
    parameter int CUT_CODE    = 149,
    parameter int REFRESH_DIV = 5,
    parameter int MASK_CYC    = 250,
    parameter int DEAD_CYC    = 125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] speed_cmd,
    input  logic             ilim,
    output logic             hs_pwm,
    output logic             ls_refresh,
    output logic             all_off,
    output logic             pwm_on_stb
);

    localparam int CNT_W = $clog2(HALF_CYC + 1);
    localparam int REF_W = HALF_CYC / REFRESH_DIV;
    localparam int RUN_W = $clog2(DEAD_CYC + 3);

    logic [CNT_W-1:0] cnt;
    logic             rising, at_bottom, at_top;
    logic             hit, pwm_lvl, on_edge, ref_en;
    logic             block_hs, oc_latched;
    logic             off_c, hs_next, ls_next;
    gate_t            gate_q;
    logic             off_q, stb_q;

    pwm_carrier #(.HALF_CYC(HALF_CYC), .CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst(rst), .cnt(cnt), .rising(rising),
        .at_bottom(at_bottom), .at_top(at_top)
    );

    pwm_compare #(
        .CMD_W(CMD_W), .HALF_CYC(HALF_CYC), .CNT_W(CNT_W),
        .ALLOFF_CODE(ALLOFF_CODE), .ZERO_CODE(ZERO_CODE),
        .FULL_CODE(FULL_CODE), .CUT_CODE(CUT_CODE)
    ) u_compare (
        .clk(clk), .rst(rst), .cmd(speed_cmd), .cnt(cnt), .rising(rising),
        .at_bottom(at_bottom), .at_top(at_top), .hit(hit),
        .pwm_lvl(pwm_lvl), .on_edge(on_edge), .ref_en(ref_en)
    );

    oc_blanker #(.MASK_CYC(MASK_CYC)) u_blanker (
        .clk(clk), .rst(rst), .ilim(ilim), .pwm_lvl(pwm_lvl),
        .on_edge(on_edge), .block_hs(block_hs), .latched(oc_latched)
    );

    // All-off acts on the live command, not on the latched level
    assign off_c   = (classify(int'(speed_cmd), ALLOFF_CODE, ZERO_CODE, CUT_CODE) == ZONE_OFF);
    assign hs_next = hit && !off_c && !block_hs;

    refresh_ctl #(.CNT_W(CNT_W), .REF_W(REF_W), .DEAD_CYC(DEAD_CYC)) u_refresh (
        .clk(clk), .rst(rst), .cnt(cnt), .ref_en(ref_en), .off_c(off_c),
        .hs_now(gate_q.hs), .hs_next(hs_next), .ls_next(ls_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            off_q  <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            gate_q.hs <= hs_next;
            gate_q.ls <= ls_next;
            off_q     <= off_c;
            stb_q     <= on_edge;
        end
    end

    assign hs_pwm     = gate_q.hs;
    assign ls_refresh = gate_q.ls;
    assign all_off    = off_q;
    assign pwm_on_stb = stb_q;

    // Checker state: consecutive cycles with the high-side gate low
    logic [RUN_W-1:0] hs_low_run;
    always_ff @(posedge clk) begin
        if (rst)
            hs_low_run <= RUN_W'(DEAD_CYC + 1);
        else if (hs_pwm)
            hs_low_run <= '0;
        else if (hs_low_run != RUN_W'(DEAD_CYC + 1))
            hs_low_run <= hs_low_run + RUN_W'(1);
    end

    p_alloff_r4: assert property (@(posedge clk) disable iff (rst)
        (speed_cmd < CMD_W'(ALLOFF_CODE)) |=> (all_off && !hs_pwm && !ls_refresh));

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        !(hs_pwm && ls_refresh));

    p_dead_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_refresh) |-> (hs_low_run == RUN_W'(DEAD_CYC + 1)));

    p_stb_hs_r9: assert property (@(posedge clk) disable iff (rst)
        (pwm_on_stb && !all_off) |-> hs_pwm);

    p_stb_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        pwm_on_stb |=> !pwm_on_stb);

    p_oc_hold_r10: assert property (@(posedge clk) disable iff (rst)
        oc_latched |-> !hs_pwm);

endmodule

// File: tb/tb_tri_pwm_refresh.sv
module tb_tri_pwm_refresh;

    localparam int H      = 100;
    localparam int OFFC   = 51;
    localparam int ZEROC  = 82;
    localparam int FULLC  = 212;
    localparam int CUTC   = 149;
    localparam int DIV    = 5;
    localparam int MASK   = 10;
    localparam int DEAD   = 3;
    localparam int REFW   = H / DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cmd = 8'd0;
    logic       ilim = 1'b0;
    logic       hs_pwm, ls_refresh, all_off, pwm_on_stb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tri_pwm_refresh #(
        .CMD_W(8), .HALF_CYC(H), .ALLOFF_CODE(OFFC), .ZERO_CODE(ZEROC),
        .FULL_CODE(FULLC), .CUT_CODE(CUTC), .REFRESH_DIV(DIV),
        .MASK_CYC(MASK), .DEAD_CYC(DEAD)
    ) dut (
        .clk(clk), .rst(rst), .speed_cmd(cmd), .ilim(ilim),
        .hs_pwm(hs_pwm), .ls_refresh(ls_refresh), .all_off(all_off),
        .pwm_on_stb(pwm_on_stb)
    );

    // Expected-value model state, derived from the requirements
    int  k = 0, last_p = -1;
    int  lvl_m = H, e_m = 0, lowrun = DEAD + 1, dut_low = DEAD + 1;
    bit  ref_m = 0, prev_hit = 0, oc_m = 0, hs_m = 0, ls_m = 0, off_m = 0, stb_m = 0;
    bit  prev_ls = 0;

    function automatic int exp_thr(input int c);
        if (c <= ZEROC) return 0;
        if (c >= FULLC) return H;
        return ((c - ZEROC) * H) / (FULLC - ZEROC);
    endfunction

    function automatic bit exp_refresh_zone(input int c);
        return (c >= ZEROC) && (c < CUTC);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: advance model at the rising edge, compare at the falling edge
    task automatic step();
        int  p, c;
        bit  up, hit, edge_v, off, trip, hs_new, ls_new;
        @(posedge clk);
        p   = k % (2 * H);
        up  = (p < H);
        c   = up ? p : (2 * H - p);
        hit = up ? (c >= lvl_m) : (c > lvl_m);
        edge_v = hit && !prev_hit;
        off = (int'(cmd) < OFFC);
        trip = !edge_v && prev_hit && ((k - e_m) > MASK) && ilim;
        if (edge_v) begin
            oc_m = 0;
            e_m  = k;
        end else if (trip) begin
            oc_m = 1;
        end
        hs_new = hit && !off && !oc_m;
        ls_new = ref_m && (c < REFW) && !off && !hs_new && !hs_m && (lowrun >= DEAD + 1);
        lowrun = hs_new ? 0 : ((lowrun > DEAD + 1) ? lowrun : lowrun + 1);
        hs_m = hs_new; ls_m = ls_new; off_m = off; stb_m = edge_v;
        prev_hit = hit;
        if (p == 0) lvl_m = H - exp_thr(int'(cmd));
        if (p == H) ref_m = exp_refresh_zone(int'(cmd));
        last_p = p;
        k++;
        @(negedge clk);
        chk("R2 R5 R10 hs_pwm", int'(hs_pwm), int'(hs_m));
        chk("R6 R7 ls_refresh", int'(ls_refresh), int'(ls_m));
        chk("R4 all_off", int'(all_off), int'(off_m));
        chk("R9 pwm_on_stb", int'(pwm_on_stb), int'(stb_m));
        chk("R8 overlap", int'(hs_pwm && ls_refresh), 0);
        if (ls_refresh && !prev_ls)
            chk("R8 dead time before refresh", int'(dut_low >= DEAD + 1), 1);
        dut_low = hs_pwm ? 0 : dut_low + 1;
        prev_ls = ls_refresh;
    endtask

    task automatic align_bottom();
        do step(); while (last_p != 0);
    endtask

    // Count outputs over one aligned period; optional ilim burst after the strobe
    task automatic count_period(input int ilim_len, output int hs_c, output int ls_c,
                                output int stb_c, output int off_c);
        int rem = 0;
        hs_c = 0; ls_c = 0; stb_c = 0; off_c = 0;
        for (int i = 0; i < 2 * H; i++) begin
            step();
            hs_c  += int'(hs_pwm);
            ls_c  += int'(ls_refresh);
            stb_c += int'(pwm_on_stb);
            off_c += int'(all_off);
            if (rem > 0) begin
                rem--;
                if (rem == 0) ilim = 1'b0;
            end
            if (pwm_on_stb && ilim_len > 0 && stb_c == 1) begin
                ilim = 1'b1;
                rem  = ilim_len;
            end
        end
        ilim = 1'b0;
    endtask

    task automatic measure(input int cv, input int ilim_len, output int hs_c,
                           output int ls_c, output int stb_c, output int off_c);
        int a, b, d, e;
        cmd = 8'(cv);
        align_bottom();
        count_period(0, a, b, d, e);
        count_period(ilim_len, hs_c, ls_c, stb_c, off_c);
    endtask

    initial begin
        int hs_c, ls_c, stb_c, off_c;
        void'($urandom(32'd20251));
        // R1: reset state
        repeat (5) @(negedge clk);
        chk("R1 reset hs_pwm", int'(hs_pwm), 0);
        chk("R1 reset ls_refresh", int'(ls_refresh), 0);
        chk("R1 reset all_off", int'(all_off), 0);
        chk("R1 reset pwm_on_stb", int'(pwm_on_stb), 0);
        cmd = 8'd120;
        rst = 1'b0;
        step();
        chk("R1 first cycle quiet", int'(hs_pwm || ls_refresh || all_off || pwm_on_stb), 0);

        // R2: duty mapping at mid and high commands
        measure(180, 0, hs_c, ls_c, stb_c, off_c);
        chk("R2 on-time cmd=180", hs_c, 2 * exp_thr(180));
        chk("R9 one strobe per period", stb_c, 1);
        chk("R7 no refresh above cut", ls_c, 0);
        measure(100, 0, hs_c, ls_c, stb_c, off_c);
        chk("R2 on-time cmd=100", hs_c, 2 * exp_thr(100));
        chk("R6 refresh width cmd=100", ls_c, 2 * REFW - 1);
        measure(CUTC - 1, 0, hs_c, ls_c, stb_c, off_c);
        chk("R6 refresh just below cut", ls_c, 2 * REFW - 1);
        chk("R2 on-time below cut", hs_c, 2 * exp_thr(CUTC - 1));
        measure(CUTC, 0, hs_c, ls_c, stb_c, off_c);
        chk("R7 refresh off at cut", ls_c, 0);

        // R5: duty end points
        measure(ZEROC, 0, hs_c, ls_c, stb_c, off_c);
        chk("R5 zero duty at zero code", hs_c, 0);
        chk("R6 refresh at zero code", ls_c, 2 * REFW - 1);
        measure(60, 0, hs_c, ls_c, stb_c, off_c);
        chk("R5 zero duty below zero code", hs_c, 0);
        chk("R4 no all-off above off code", off_c, 0);
        measure(FULLC, 0, hs_c, ls_c, stb_c, off_c);
        chk("R5 full duty at full code", hs_c, 2 * H);
        chk("R9 no strobe at steady full duty", stb_c, 0);
        measure(255, 0, hs_c, ls_c, stb_c, off_c);
        chk("R5 full duty at max code", hs_c, 2 * H);

        // R4: all-off acts at once, in mid-pulse
        cmd = 8'd255;
        repeat (7) step();
        cmd = 8'(OFFC - 1);
        step();
        chk("R4 all_off immediate", int'(all_off), 1);
        chk("R4 hs off immediate", int'(hs_pwm), 0);
        measure(OFFC - 1, 0, hs_c, ls_c, stb_c, off_c);
        chk("R4 all-off period hs", hs_c, 0);
        chk("R4 all-off period ls", ls_c, 0);
        chk("R4 all-off period flag", off_c, 2 * H);
        measure(OFFC, 0, hs_c, ls_c, stb_c, off_c);
        chk("R4 off code itself not all-off", off_c, 0);

        // R3: mid-period command change keeps running on-time
        cmd = 8'd180;
        align_bottom();
        align_bottom();
        hs_c = 0;
        for (int i = 0; i < 2 * H; i++) begin
            step();
            hs_c += int'(hs_pwm);
            if (i == H / 2) cmd = 8'd100;
        end
        chk("R3 old duty kept until bottom", hs_c, 2 * exp_thr(180));

        // R10 / R11: blanking and latched cut
        measure(180, MASK, hs_c, ls_c, stb_c, off_c);
        chk("R11 ilim inside mask ignored", hs_c, 2 * exp_thr(180));
        measure(180, MASK + 1, hs_c, ls_c, stb_c, off_c);
        chk("R10 cut after mask", hs_c, MASK + 1);
        count_period(0, hs_c, ls_c, stb_c, off_c);
        chk("R10 released at next on edge", hs_c, 2 * exp_thr(180));

        // Random commands and current-limit activity
        for (int seg = 0; seg < 40; seg++) begin
            int len;
            cmd = 8'($urandom % 256);
            len = 50 + int'($urandom % 350);
            for (int i = 0; i < len; i++) begin
                ilim = (($urandom % 8) == 0);
                step();
            end
        end
        ilim = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule